// File: doc/BRIEF.md
# Triggered Six-Step Pulse Sequencer

This block is a small Moore state machine that waits in an idle code until a one-bit start input is sampled high. It then walks through a fixed six-code ring. Between any two neighbouring codes only a single state bit changes. After the last code it returns to idle. In the last code before idle the block raises a one-cycle output pulse. This makes it usable as a delayed, fixed-width strobe generator that fires once per accepted start request.

The next-state and pulse logic is a programmable-array style sum-of-products network. The network is a generic AND plane and OR plane whose term masks live in a package. The three state bits and the pulse bit are each held in their own D flip-flop. The present state is brought out for observation. A parameter selects the code loaded by the synchronous reset. It defaults to idle and exists so that the two unused codes can be entered and their recovery observed.

Top module: `jpg_pulse_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state is loaded with `INIT_CODE` (default 3'b000) and `pulse` is loaded with 1 only if `INIT_CODE` is 3'b100.
- R2: In state 3'b000 with `trig`=0 at a clock edge, the state remains 3'b000.
- R3: In state 3'b000 with `trig`=1 at a clock edge, the next state is 3'b001.
- R4: From 3'b001 the state advances one code per clock through 3'b011, 3'b111, 3'b110, 3'b100 and back to 3'b000, independent of `trig`.
- R5: `pulse` is 1 exactly in the cycles in which `state_obs` is 3'b100, and it comes from a flip-flop rather than from combinational decoding.
- R6: If `trig`=1 is sampled in idle in cycle c, `pulse` is high in cycle c+5 and low again in cycle c+6.
- R7: The unused codes 3'b010 and 3'b101 go to 3'b000 on the next clock for either value of `trig`.
- R8: `trig` is ignored outside idle. When `trig` is held high, the block re-enters 3'b001 on the clock right after it reaches 3'b000, so runs repeat back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Start request, sampled only in idle |
| pulse | output | 1 | Registered one-cycle strobe in the last code of a run |
| state_obs | output | 3 | Present state code, bit 2 first |

## Verification
The hardest situation to reach from the ports is presence in one of the two unused codes, because no legal input sequence leads there. The bench adds two extra instances whose reset code is 3'b010 and 3'b101. It releases reset with `trig` low once and with `trig` high once, then checks that each instance lands in idle after one edge. Legal codes are covered under both input values by running a pseudo-random `trig` pattern alongside long held-high stretches. A behavioural reference model is compared against the design on every clock.

// File: rtl/jpg_pkg.sv
package jpg_pkg;
  localparam int ST_W    = 3;
  localparam int IN_W    = ST_W + 1;   // {state, trig}
  localparam int OUT_W   = ST_W + 1;   // {next state, next pulse}
  localparam int N_TERMS = 5;

  typedef logic [ST_W-1:0] code_t;

  localparam code_t C_IDLE = 3'b000;
  localparam code_t C_FIRE = 3'b100;

  // Product terms, input bit order {s2, s1, s0, trig}:
  //  t0 = s1&s0   t1 = s2&s1   t2 = ~s2&s0
  //  t3 = ~s2&~s1&~s0&trig     t4 = s2&s1&~s0
  localparam logic [N_TERMS*IN_W-1:0] AND_CARE =
    {4'b1110, 4'b1111, 4'b1010, 4'b1100, 4'b0110};
  localparam logic [N_TERMS*IN_W-1:0] AND_VAL =
    {4'b1100, 4'b0001, 4'b0010, 4'b1100, 4'b0110};

  // Sums, output order {d2, d1, d0, pulse_next}:
  //  d2 = t0|t1   d1 = t0|t2   d0 = t2|t3   pulse_next = t4
  localparam logic [OUT_W*N_TERMS-1:0] OR_SEL =
    {5'b00011, 5'b00101, 5'b01100, 5'b10000};
endpackage

// File: rtl/jpg_pla.sv
module jpg_pla #(
  parameter int N_IN    = 4,
  parameter int N_OUT   = 4,
  parameter int N_TERMS = 5,
  parameter logic [N_TERMS*N_IN-1:0]  CARE = '0,
  parameter logic [N_TERMS*N_IN-1:0]  VAL  = '0,
  parameter logic [N_OUT*N_TERMS-1:0] SEL  = '0
) (
  input  logic [N_IN-1:0]  in_vec,
  output logic [N_OUT-1:0] out_vec
);
  logic [N_TERMS-1:0] term;

  // AND plane: a term is true when every cared-for input matches its value
  for (genvar t = 0; t < N_TERMS; t++) begin : g_and
    assign term[t] = &(~(in_vec ^ VAL[t*N_IN +: N_IN]) | ~CARE[t*N_IN +: N_IN]);
  end

  // OR plane: each output sums the terms selected for it
  for (genvar o = 0; o < N_OUT; o++) begin : g_or
    assign out_vec[o] = |(term & SEL[o*N_TERMS +: N_TERMS]);
  end
endmodule

// File: rtl/jpg_dff_bank.sv
module jpg_dff_bank #(
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_ff
    always_ff @(posedge clk) begin
      if (rst) q[b] <= RST_VAL[b];
      else     q[b] <= d[b];
    end
  end
endmodule

// File: rtl/jpg_pulse_gen.sv
module jpg_pulse_gen
  import jpg_pkg::*;
#(
  parameter logic [2:0] INIT_CODE = 3'b000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       trig,
  output logic       pulse,
  output logic [2:0] state_obs
);
  localparam logic [0:0] PULSE_RST = (INIT_CODE == C_FIRE) ? 1'b1 : 1'b0;

  code_t            st_q;
  logic [IN_W-1:0]  plane_in;
  logic [OUT_W-1:0] plane_out;

  assign plane_in = {st_q, trig};

  jpg_pla #(
    .N_IN(IN_W), .N_OUT(OUT_W), .N_TERMS(N_TERMS),
    .CARE(AND_CARE), .VAL(AND_VAL), .SEL(OR_SEL)
  ) u_pla (
    .in_vec (plane_in),
    .out_vec(plane_out)
  );

  jpg_dff_bank #(.W(ST_W), .RST_VAL(INIT_CODE)) u_state (
    .clk(clk), .rst(rst), .d(plane_out[OUT_W-1:1]), .q(st_q)
  );

  jpg_dff_bank #(.W(1), .RST_VAL(PULSE_RST)) u_pulse (
    .clk(clk), .rst(rst), .d(plane_out[0]), .q(pulse)
  );

  assign state_obs = st_q;
endmodule

// File: rtl/jpg_pulse_gen_chk.sv
module jpg_pulse_gen_chk #(
  parameter logic [2:0] INIT_CODE = 3'b000
) (
  input logic       clk,
  input logic       rst,
  input logic       trig,
  input logic       pulse,
  input logic [2:0] state_obs
);
  a_r1_reset_code: assert property (@(posedge clk)
    rst |=> state_obs == INIT_CODE);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (state_obs == 3'b000 && !trig) |=> state_obs == 3'b000);

  a_r3_start: assert property (@(posedge clk) disable iff (rst)
    (state_obs == 3'b000 && trig) |=> state_obs == 3'b001);

  a_r4_step_a: assert property (@(posedge clk) disable iff (rst)
    state_obs == 3'b001 |=> state_obs == 3'b011);

  a_r4_step_b: assert property (@(posedge clk) disable iff (rst)
    state_obs == 3'b111 |=> state_obs == 3'b110);

  a_r4_step_c: assert property (@(posedge clk) disable iff (rst)
    state_obs == 3'b100 |=> state_obs == 3'b000);

  a_r4_one_bit: assert property (@(posedge clk) disable iff (rst)
    (state_obs != 3'b000 && state_obs != 3'b010 && state_obs != 3'b101)
      |=> $countones(state_obs ^ $past(state_obs)) == 1);

  a_r5_pulse_state: assert property (@(posedge clk) disable iff (rst)
    pulse == (state_obs == 3'b100));

  a_r6_delay: assert property (@(posedge clk) disable iff (rst)
    (state_obs == 3'b000 && trig) |-> ##5 pulse);

  a_r6_width: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  a_r7_recover: assert property (@(posedge clk) disable iff (rst)
    (state_obs == 3'b010 || state_obs == 3'b101) |=> state_obs == 3'b000);
endmodule

bind jpg_pulse_gen jpg_pulse_gen_chk #(.INIT_CODE(INIT_CODE)) u_chk (
  .clk(clk), .rst(rst), .trig(trig), .pulse(pulse), .state_obs(state_obs)
);

// File: tb/jpg_pulse_gen_test.sv
`timescale 1ns/100ps
module jpg_pulse_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trig = 1'b0;
  logic       pulse, pulse_a, pulse_b;
  logic [2:0] st, st_a, st_b;

  int checks = 0;
  int failures = 0;
  int mpos = 0;          // reference position in the ring, 0 = idle
  logic [7:0] lfsr = 8'hA5;

  always #2.5 clk = ~clk;

  jpg_pulse_gen uut (.clk(clk), .rst(rst), .trig(trig), .pulse(pulse), .state_obs(st));
  jpg_pulse_gen #(.INIT_CODE(3'b010)) uut_i010 (.clk(clk), .rst(rst), .trig(trig), .pulse(pulse_a), .state_obs(st_a));
  jpg_pulse_gen #(.INIT_CODE(3'b101)) uut_i101 (.clk(clk), .rst(rst), .trig(trig), .pulse(pulse_b), .state_obs(st_b));

  function automatic logic [2:0] ring_code(int p);
    case (p)
      1: return 3'b001;
      2: return 3'b011;
      3: return 3'b111;
      4: return 3'b110;
      5: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // compare at negedge, drive, clock, advance reference, return at negedge
  task automatic step(input logic x, input string tag);
    chk(st == ring_code(mpos), tag, st, ring_code(mpos));
    chk(pulse == (mpos == 5), "R5", pulse, (mpos == 5));
    trig = x;
    @(posedge clk);
    if (mpos == 0) mpos = x ? 1 : 0;
    else           mpos = (mpos + 1) % 6;
    @(negedge clk);
  endtask

  function automatic string tag_for(logic x);
    if (mpos == 0) return x ? "R3" : "R2";
    return x ? "R8" : "R4";
  endfunction

  task automatic do_reset(input logic x);
    rst = 1'b1;
    trig = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(st == 3'b000, "R1", st, 0);
    chk(pulse == 1'b0, "R1", pulse, 0);
    chk(st_a == 3'b010, "R1", st_a, 2);
    chk(st_b == 3'b101, "R1", st_b, 5);
    rst = 1'b0;
    trig = x;
    @(posedge clk);
    mpos = x ? 1 : 0;
    @(negedge clk);
    chk(st_a == 3'b000, "R7", st_a, 0);
    chk(st_b == 3'b000, "R7", st_b, 0);
    chk(pulse_a == 1'b0 && pulse_b == 1'b0, "R7", {pulse_a, pulse_b}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(1'b0);

    // R2: idle with trig low
    for (int i = 0; i < 5; i++) step(1'b0, "R2");

    // R6: single trigger, pulse in fifth cycle after, one cycle wide
    begin
      int seen = -1;
      int width = 0;
      step(1'b1, "R3");
      for (int i = 1; i <= 8; i++) begin
        if (pulse && seen < 0) seen = i;
        if (pulse) width++;
        step(1'b0, "R4");
      end
      chk(seen == 5, "R6", seen, 5);
      chk(width == 1, "R6", width, 1);
    end

    // R8: trig held high, back-to-back runs, ignored mid-run
    for (int i = 0; i < 20; i++) step(1'b1, tag_for(1'b1));
    chk(mpos != 0, "R8", mpos, 1);

    // mixed pattern covering every legal code under both trig values
    for (int i = 0; i < 300; i++) begin
      logic x;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      x = lfsr[0];
      step(x, tag_for(x));
    end

    // R7 with trig high, R1 again mid-run
    do_reset(1'b1);
    for (int i = 0; i < 8; i++) step(1'b0, tag_for(1'b0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule